// File: doc/BRIEF.md
# Four-Digit Multiplexed Seven-Segment Scanner

This block drives a four-digit seven-segment display in which all digits share one set of segment lines and each digit has its own anode enable. A small registered scan index walks through the digit positions, one step per pulse of a refresh enable. The same index feeds two paths. A one-hot anode decoder switches on the current digit. A bus multiplexer picks that digit's 4-bit value and passes it through a hexadecimal glyph decoder to the segment lines.

In use, the refresh enable is a single-cycle strobe at about 1 kHz from a divider elsewhere in the chip. Each digit is then lit for one strobe period out of four, about 250 Hz per digit, which the eye sees as a steady four-digit readout. The four digit values come from a counter or register file and may change at any time. The decimal point is held dark.

Top module: `disp_scan_top`

## Requirements
- R1: While `rst` is high, every anode output is high (all digits dark). A clock edge with `rst` high clears the scan index to 0, so the first cycle after reset lights digit 0 (`an_n` = 4'b1110).
- R2: The scan index advances by one at each rising clock edge where `refresh_en` is high and `rst` is low. It holds its value at every edge where `refresh_en` is low.
- R3: Outside reset, exactly one anode is low. Bit k of `an_n` is low exactly when the scan index equals k.
- R4: The segment lines show the value of the digit that the scan index selects. Digit k is `digits[4k+3:4k]`.
- R5: The segments are active low, with bit order `seg_n[6:0]` = {g,f,e,d,c,b,a}. In active-high hex, the lit patterns for 0 to F are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 77, 7C, 39, 5E, 79, 71. Values 10 to 15 show A, b, C, d, E, F.
- R6: The decimal point output `dp_n` is high (off) at all times.
- R7: The anode and the segment pattern switch on the same clock edge. A change on `digits` appears on `seg_n` within the same cycle, with no register in between.
- R8: After the index reaches 3, the next refresh step returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also blanks the anodes |
| refresh_en | input | 1 | One-cycle strobe that advances the scan index |
| digits | input | 16 | Four 4-bit digit values; digit k in bits 4k+3:4k |
| an_n | output | 4 | Anode enables, active low, one per digit |
| seg_n | output | 7 | Segment lines {g,f,e,d,c,b,a}, active low |
| dp_n | output | 1 | Decimal point, active low, held off |

## Verification
The scan index is the only register, so a strobe sampled at an edge changes both `an_n` and `seg_n` in the cycle that starts at that edge. A change on `digits` shows on `seg_n` with no clock edge at all. The bench keeps a behavioural index that updates at each rising edge from the inputs it drove half a period earlier. It compares all outputs 1 ns after every edge, when the design and the model have both settled. One directed check changes a digit between edges and reads the segments before the next edge, which proves the path from `digits` to `seg_n` has no register.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;

   // Lit pattern of a hex value, active high, bit order {g,f,e,d,c,b,a}.
   function automatic logic [6:0] hex_glyph(input logic [3:0] v);
      logic [6:0] g;
      case (v)
         4'h0: g = 7'h3F;
         4'h1: g = 7'h06;
         4'h2: g = 7'h5B;
         4'h3: g = 7'h4F;
         4'h4: g = 7'h66;
         4'h5: g = 7'h6D;
         4'h6: g = 7'h7D;
         4'h7: g = 7'h07;
         4'h8: g = 7'h7F;
         4'h9: g = 7'h6F;
         4'hA: g = 7'h77;
         4'hB: g = 7'h7C;
         4'hC: g = 7'h39;
         4'hD: g = 7'h5E;
         4'hE: g = 7'h79;
         default: g = 7'h71;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/disp_scan_ctr.sv
module disp_scan_ctr #(
   parameter int COUNT = 4,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   output logic [SEL_W-1:0] sel
);
   localparam logic [SEL_W-1:0] LAST = SEL_W'(COUNT - 1);

   always_ff @(posedge clk) begin
      if (rst)
         sel <= '0;
      else if (step)
         sel <= (sel == LAST) ? '0 : sel + 1'b1;
   end

   // R2 / R8: one step per strobe, wrapping after the last position
   assert_step_R2: assert property (@(posedge clk) disable iff (rst)
      step |=> (sel == (($past(sel) == LAST) ? '0 : $past(sel) + 1'b1)));

   // R2: no strobe, no movement
   assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(sel));

endmodule

// File: rtl/disp_scan_anode.sv
module disp_scan_anode #(
   parameter int COUNT      = 4,
   parameter int SEL_W      = 2,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             blank,
   input  logic [SEL_W-1:0] sel,
   output logic [COUNT-1:0] an
);
   logic [COUNT-1:0] hit;

   for (genvar k = 0; k < COUNT; k++) begin : g_line
      assign hit[k] = (sel == SEL_W'(k)) & ~blank;
   end

   if (ACTIVE_LOW) begin : g_low
      assign an = ~hit;
   end else begin : g_high
      assign an = hit;
   end

   // R3: exactly one digit enabled whenever not blanked
   assert_one_anode_R3: assert property (@(posedge clk) disable iff (blank)
      $countones(hit) == 1);

endmodule

// File: rtl/disp_scan_mux.sv
module disp_scan_mux #(
   parameter int COUNT   = 4,
   parameter int DIGIT_W = 4,
   parameter int SEL_W   = 2
) (
   input  logic [COUNT*DIGIT_W-1:0] digits,
   input  logic [SEL_W-1:0]         sel,
   output logic [DIGIT_W-1:0]       value
);
   logic [DIGIT_W-1:0] lane [COUNT];

   for (genvar k = 0; k < COUNT; k++) begin : g_lane
      assign lane[k] = digits[k*DIGIT_W +: DIGIT_W];
   end

   always_comb begin
      value = '0;
      for (int i = 0; i < COUNT; i++) begin
         if (sel == SEL_W'(i)) value = lane[i];
      end
   end

endmodule

// File: rtl/disp_scan_seg.sv
module disp_scan_seg #(
   parameter int DIGIT_W    = 4,
   parameter int SEG_W      = 7,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic [DIGIT_W-1:0] value,
   output logic [SEG_W-1:0]   seg
);
   import disp_scan_pkg::*;

   logic [SEG_W-1:0] lit;

   assign lit = SEG_W'(hex_glyph(value[3:0]));

   if (ACTIVE_LOW) begin : g_low
      assign seg = ~lit;
   end else begin : g_high
      assign seg = lit;
   end

endmodule

// File: rtl/disp_scan_top.sv
module disp_scan_top #(
   parameter int NUM_DIGITS = 4,
   parameter int DIGIT_W    = 4,
   parameter int SEG_W      = 7,
   parameter bit AN_LOW     = 1'b1,
   parameter bit SEG_LOW    = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          refresh_en,
   input  logic [NUM_DIGITS*DIGIT_W-1:0] digits,
   output logic [NUM_DIGITS-1:0]         an_n,
   output logic [SEG_W-1:0]              seg_n,
   output logic                          dp_n
);
   localparam int SEL_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
   localparam logic [NUM_DIGITS-1:0] AN_OFF = AN_LOW ? '1 : '0;

   if (NUM_DIGITS < 2) begin : g_chk_n
      $error("disp_scan_top: NUM_DIGITS must be at least 2");
   end
   if (DIGIT_W != 4) begin : g_chk_dw
      $error("disp_scan_top: DIGIT_W must be 4 for the hex glyph decoder");
   end
   if (SEG_W != 7) begin : g_chk_sw
      $error("disp_scan_top: SEG_W must be 7");
   end

   logic [SEL_W-1:0]   sel;
   logic [DIGIT_W-1:0] cur;

   disp_scan_ctr #(.COUNT(NUM_DIGITS), .SEL_W(SEL_W)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .step (refresh_en),
      .sel  (sel)
   );

   disp_scan_anode #(.COUNT(NUM_DIGITS), .SEL_W(SEL_W), .ACTIVE_LOW(AN_LOW)) u_anode (
      .clk   (clk),
      .blank (rst),
      .sel   (sel),
      .an    (an_n)
   );

   disp_scan_mux #(.COUNT(NUM_DIGITS), .DIGIT_W(DIGIT_W), .SEL_W(SEL_W)) u_mux (
      .digits (digits),
      .sel    (sel),
      .value  (cur)
   );

   disp_scan_seg #(.DIGIT_W(DIGIT_W), .SEG_W(SEG_W), .ACTIVE_LOW(SEG_LOW)) u_seg (
      .value (cur),
      .seg   (seg_n)
   );

   assign dp_n = SEG_LOW;

   // R1: all digits dark while reset is held
   assert_reset_dark_R1: assert property (@(posedge clk)
      rst |-> (an_n == AN_OFF));

   // R7: a move of the scan index moves the anode on the same edge
   assert_same_edge_R7: assert property (@(posedge clk) disable iff (rst)
      (sel != $past(sel)) |-> (an_n != $past(an_n)));

endmodule

// File: tb/disp_scan_top_bench.sv
`timescale 1ns/1ps
module disp_scan_top_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        refresh_en = 1'b0;
   logic [15:0] digits = 16'h0000;
   logic [3:0]  an_n;
   logic [6:0]  seg_n;
   logic        dp_n;

   int checks = 0;
   int fails  = 0;
   int ref_idx = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   disp_scan_top u_disp_scan_top (
      .clk(clk), .rst(rst), .refresh_en(refresh_en), .digits(digits),
      .an_n(an_n), .seg_n(seg_n), .dp_n(dp_n)
   );

   function automatic logic [6:0] want_lit(input logic [3:0] v);
      case (v)
         4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
         4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
         4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
         4'd9: return 7'h6F;  4'd10: return 7'h77; 4'd11: return 7'h7C;
         4'd12: return 7'h39; 4'd13: return 7'h5E; 4'd14: return 7'h79;
         default: return 7'h71;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input logic [15:0] act,
                        input logic [15:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference: index updated at each edge from the driven inputs
   always @(posedge clk) begin
      if (rst) ref_idx = 0;
      else if (refresh_en) ref_idx = (ref_idx + 1) % 4;
   end

   // Compare every cycle, 1 ns after the edge
   always @(posedge clk) begin
      #1;
      if (rst) begin
         check(an_n == 4'hF, "R1 anodes dark in reset", 16'(an_n), 16'hF);
      end else begin
         logic [3:0] ea;
         logic [6:0] es;
         ea = ~(4'b0001 << ref_idx);
         es = ~want_lit(digits[ref_idx*4 +: 4]);
         check(an_n == ea, "R3 anode select", 16'(an_n), 16'(ea));
         check(seg_n == es, "R4/R5 segment glyph", 16'(seg_n), 16'(es));
      end
      check(dp_n == 1'b1, "R6 decimal point off", 16'(dp_n), 16'h1);
   end

   task automatic cycle(input bit en);
      @(negedge clk);
      refresh_en = en;
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      digits = 16'h3210;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(an_n == 4'b1110, "R1 digit 0 first after reset", 16'(an_n), 16'hE);

      // R2: hold without strobe
      repeat (5) cycle(1'b0);
      #0.1;
      check(an_n == 4'b1110, "R2 index holds without strobe", 16'(an_n), 16'hE);

      // R2 / R8: step through all positions and wrap
      for (int i = 0; i < 4; i++) begin
         cycle(1'b1);
      end
      cycle(1'b0);
      #0.1;
      check(an_n == 4'b1110, "R8 wrap back to digit 0", 16'(an_n), 16'hE);

      // R7: digit change shows on segments with no clock edge
      @(negedge clk);
      digits[3:0] = 4'hA;
      #0.5;
      check(seg_n == ~7'h77, "R7 segments follow digit within cycle",
            16'(seg_n), 16'(~7'h77));

      // R5: every value 0..F on every position
      for (int v = 0; v < 16; v++) begin
         @(negedge clk);
         digits = {4'((v + 3) % 16), 4'((v + 2) % 16), 4'((v + 1) % 16), 4'(v)};
         refresh_en = 1'b1;
         repeat (4) cycle(1'b1);
      end

      // Mixed strobes, random digits, mid-run reset pulses
      for (int n = 0; n < 3000; n++) begin
         @(negedge clk);
         refresh_en = ($urandom % 3) == 0;
         if (($urandom % 7) == 0) digits = 16'($urandom);
         rst = ($urandom % 200) == 0;
      end
      @(negedge clk);
      rst = 1'b0;
      refresh_en = 1'b0;
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule